// File: doc/BRIEF.md
# Serial Control Register File Slave

This block is the device-side end of a three-line serial control link: a frame-enable line (active low), a serial clock and a serial data line. While the enable line is low, the block collects one bit on every rising edge of the serial clock. When the enable line returns high, the frame is judged as a whole. A valid write frame for this device stores one byte into a 32-row by 8-bit register file. A valid read frame arms a readout. The writable rows drive a flat bus of control bits to the circuits they configure. Four read-only rows show live status inputs: a lock flag, three oscillator amplitude flags, two 8-bit tuning monitors and a thermometer-coded temperature.

The three serial lines are asynchronous to the system clock. They pass through a synchronizer chain and are then edge-detected in the system clock domain, so the serial clock must run well below the system clock. A state machine owns the frame and has four states:
- `ST_IDLE` goes to `ST_SHIFT` when the enable line falls.
- `ST_SHIFT` goes to `ST_RD_ARMED` when the enable line rises after a valid read frame, and to `ST_IDLE` when it rises after any other frame. The row write is issued on that same transition when the frame is a valid write.
- `ST_RD_ARMED` goes to `ST_RD_OUT` when the enable line falls.
- `ST_RD_OUT` goes to `ST_IDLE` when the enable line rises.

Top module: `ctl_regfile_slave`

## Requirements
- R1: After reset, every control bit is 0 and the serial output is 0.
- R2: A frame is 18 bits, each field least significant bit first. Bit positions 0 to 7 are the data byte, 8 to 13 the row address, 14 the direction (1 = write), and 15 to 17 the device address. A valid write frame stores the data byte in the addressed row.
- R3: No control bit changes during a frame. The addressed row changes only after the enable line rises.
- R4: Frames whose device address is not binary 111 are ignored, for both writes and reads.
- R5: Rows 24 to 27 are read-only and rows 28 to 31 have no storage. Writes to any of these rows have no effect, and rows 28 to 31 always read as 0.
- R6: A frame whose enable line rises after any number of serial clock rises other than 18 is discarded.
- R7: A frame whose row address has bit 5 set is discarded.
- R8: After a valid read frame, the next enable-low window drives the addressed row on the serial output, least significant bit first. Bit 0 is present before the first serial clock rise, and each rise advances one bit. Bits past the eighth read 0. The output is 0 outside that window.
- R9: Row 24 bits [3:0] are {lock, amplitude-down, amplitude-up, amplitude-centre}. Row 25 is the positive tuning monitor. Row 26 is the negative tuning monitor. Row 27 bits [4:0] are the thermometer-coded temperature, with 00000 coldest and 11111 hottest. All other bits of these rows read 0.
- R10: Row r (0 to 23) appears on control bits [8r+7:8r].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_en_n | input | 1 | Frame enable, active low; rising edge commits |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial readout data |
| ctrl_bits | output | 192 | Rows 0 to 23, flattened |
| stat_lock | input | 1 | Lock status flag |
| stat_amp_dn | input | 1 | Amplitude-low flag |
| stat_amp_up | input | 1 | Amplitude-high flag |
| stat_amp_ctr | input | 1 | Amplitude-centred flag |
| stat_tune_p | input | 8 | Positive tuning monitor |
| stat_tune_n | input | 8 | Negative tuning monitor |
| stat_temp | input | 5 | Thermometer-coded temperature |

## Verification
The bench builds the block with its default parameters: 32 rows, 24 of them writable, a two-stage synchronizer and device address 111. With these values the bench can reach both edges of the writable range (rows 0 and 23), the first read-only row and the unstored rows above it. The same values put the 18-bit frame length in reach from both sides, with 17-bit and 19-bit frames, and make rejection of an out-of-range address bit observable.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_RD_ARMED,
        ST_RD_OUT
    } rfs_state_e;

    localparam int LINE_CLK = 0;
    localparam int LINE_EN  = 1;
    localparam int LINE_DIN = 2;
    localparam int NUM_LINES = 3;

endpackage

// File: rtl/rfs_line_sync.sv
module rfs_line_sync #(
    parameter int         W        = 3,
    parameter int         STAGES   = 2,
    parameter logic [W-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_in,
    output logic [W-1:0] lines_q
);

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= IDLE_VAL;
                    else        chain[g] <= lines_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= IDLE_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign lines_q = chain[STAGES-1];

endmodule

// File: rtl/rfs_frame_fsm.sv
module rfs_frame_fsm
    import rfs_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         ADDR_W    = 6,
    parameter int         CHIP_W    = 3,
    parameter logic [CHIP_W-1:0] CHIP_ID = '1,
    parameter int         ROW_IDX_W = 5,
    parameter int         RO_FIRST  = 24,
    localparam int        FRAME_BITS = DATA_W + ADDR_W + 1 + CHIP_W,
    localparam int        CNT_W      = $clog2(FRAME_BITS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 en_s,
    input  logic                 din_s,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 wr_en,
    output logic [ROW_IDX_W-1:0] wr_row,
    output logic [DATA_W-1:0]    wr_data,
    output logic [ROW_IDX_W-1:0] rd_row,
    output logic                 ser_dout,
    output logic [CNT_W-1:0]     bit_cnt
);

    localparam int RW_POS   = DATA_W + ADDR_W;
    localparam int CHIP_LSB = RW_POS + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

    rfs_state_e state_q, state_d;

    logic                  sclk_prev_q, en_prev_q;
    logic                  sclk_rise, en_rise, en_fall;
    logic [FRAME_BITS-1:0] frame_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [DATA_W-1:0]     out_q;
    logic                  rd_load;

    logic [DATA_W-1:0]     f_data;
    logic [ADDR_W-1:0]     f_addr;
    logic                  f_rw;
    logic [CHIP_W-1:0]     f_chip;
    logic [ROW_IDX_W-1:0]  f_row;
    logic                  addr_ok, frame_ok, row_writable;

    // Edge detection of the synchronized lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            en_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            en_prev_q   <= en_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign en_rise   = en_s & ~en_prev_q;
    assign en_fall   = ~en_s & en_prev_q;

    // Field decode of the collected frame
    assign f_data  = frame_q[DATA_W-1:0];
    assign f_addr  = frame_q[DATA_W +: ADDR_W];
    assign f_rw    = frame_q[RW_POS];
    assign f_chip  = frame_q[CHIP_LSB +: CHIP_W];
    assign f_row   = f_addr[ROW_IDX_W-1:0];
    assign addr_ok = (f_addr[ADDR_W-1:ROW_IDX_W] == '0);
    assign frame_ok     = (cnt_q == CNT_FULL) && (f_chip == CHIP_ID) && addr_ok;
    assign row_writable = (int'(f_row) < RO_FIRST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_fall) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (en_rise) begin
                    if (frame_ok && !f_rw) state_d = ST_RD_ARMED;
                    else                   state_d = ST_IDLE;
                end
            end
            ST_RD_ARMED: begin
                if (en_fall) state_d = ST_RD_OUT;
            end
            ST_RD_OUT: begin
                if (en_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        wr_en    = 1'b0;
        rd_load  = 1'b0;
        ser_dout = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_SHIFT: begin
                wr_en   = en_rise && frame_ok && f_rw && row_writable;
                rd_load = en_rise && frame_ok && !f_rw;
            end
            ST_RD_ARMED: ;
            ST_RD_OUT: begin
                ser_dout = out_q[0];
            end
            default: ;
        endcase
    end

    // Frame shifter, bit counter and readout shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            cnt_q   <= '0;
            out_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && en_fall) begin
                cnt_q   <= '0;
                frame_q <= '0;
            end else if (state_q == ST_SHIFT && sclk_rise) begin
                frame_q <= {din_s, frame_q[FRAME_BITS-1:1]};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end

            if (rd_load) begin
                out_q <= rd_data;
            end else if (state_q == ST_RD_OUT && sclk_rise) begin
                out_q <= {1'b0, out_q[DATA_W-1:1]};
            end
        end
    end

    assign wr_row  = f_row;
    assign wr_data = f_data;
    assign rd_row  = f_row;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/rfs_reg_array.sv
module rfs_reg_array #(
    parameter int  ROWS      = 32,
    parameter int  ROW_W     = 8,
    parameter int  WR_ROWS   = 24,
    parameter int  STAT_ROWS = 4,
    localparam int IDX_W     = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_row,
    input  logic [ROW_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]           rd_row,
    input  logic [STAT_ROWS*ROW_W-1:0] stat_flat,
    output logic [ROW_W-1:0]           rd_data,
    output logic [WR_ROWS*ROW_W-1:0]   ctrl_flat
);

    logic [ROW_W-1:0] rows_q [WR_ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < WR_ROWS; r++) rows_q[r] <= '0;
        end else if (wr_en && int'(wr_row) < WR_ROWS) begin
            rows_q[wr_row] <= wr_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < WR_ROWS; g++) begin : g_flat
            assign ctrl_flat[g*ROW_W +: ROW_W] = rows_q[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_row) < WR_ROWS) begin
            rd_data = rows_q[rd_row];
        end else if (int'(rd_row) < WR_ROWS + STAT_ROWS) begin
            rd_data = stat_flat[(int'(rd_row) - WR_ROWS)*ROW_W +: ROW_W];
        end
    end

endmodule

// File: rtl/ctl_regfile_slave.sv
module ctl_regfile_slave
    import rfs_pkg::*;
#(
    parameter int        ROWS        = 32,
    parameter int        ROW_W       = 8,
    parameter int        WR_ROWS     = 24,
    parameter int        ADDR_W      = 6,
    parameter int        CHIP_W      = 3,
    parameter logic [2:0] CHIP_ID    = 3'b111,
    parameter int        SYNC_STAGES = 2,
    parameter int        TUNE_W      = 8,
    parameter int        TEMP_W      = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_en_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic [WR_ROWS*ROW_W-1:0] ctrl_bits,
    input  logic                     stat_lock,
    input  logic                     stat_amp_dn,
    input  logic                     stat_amp_up,
    input  logic                     stat_amp_ctr,
    input  logic [TUNE_W-1:0]        stat_tune_p,
    input  logic [TUNE_W-1:0]        stat_tune_n,
    input  logic [TEMP_W-1:0]        stat_temp
);

    localparam int ROW_IDX_W  = $clog2(ROWS);
    localparam int STAT_ROWS  = 4;
    localparam int FRAME_BITS = ROW_W + ADDR_W + 1 + CHIP_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [NUM_LINES-1:0] LINE_IDLE = NUM_LINES'(1) << LINE_EN;

    logic [NUM_LINES-1:0] lines_raw, lines_s;
    logic                 wr_en;
    logic [ROW_IDX_W-1:0] wr_row, rd_row;
    logic [ROW_W-1:0]     wr_data, rd_data;
    logic [CNT_W-1:0]     bit_cnt;
    logic [STAT_ROWS*ROW_W-1:0] stat_flat;

    always_comb begin
        lines_raw           = '0;
        lines_raw[LINE_CLK] = ser_clk;
        lines_raw[LINE_EN]  = ser_en_n;
        lines_raw[LINE_DIN] = ser_din;
    end

    // Status rows, in row order above the writable rows
    always_comb begin
        stat_flat = '0;
        stat_flat[0*ROW_W +: 4]      = {stat_lock, stat_amp_dn, stat_amp_up, stat_amp_ctr};
        stat_flat[1*ROW_W +: TUNE_W] = stat_tune_p;
        stat_flat[2*ROW_W +: TUNE_W] = stat_tune_n;
        stat_flat[3*ROW_W +: TEMP_W] = stat_temp;
    end

    rfs_line_sync #(
        .W        (NUM_LINES),
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (LINE_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (lines_raw),
        .lines_q  (lines_s)
    );

    rfs_frame_fsm #(
        .DATA_W    (ROW_W),
        .ADDR_W    (ADDR_W),
        .CHIP_W    (CHIP_W),
        .CHIP_ID   (CHIP_ID),
        .ROW_IDX_W (ROW_IDX_W),
        .RO_FIRST  (WR_ROWS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[LINE_CLK]),
        .en_s     (lines_s[LINE_EN]),
        .din_s    (lines_s[LINE_DIN]),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_data  (wr_data),
        .rd_row   (rd_row),
        .ser_dout (ser_dout),
        .bit_cnt  (bit_cnt)
    );

    rfs_reg_array #(
        .ROWS      (ROWS),
        .ROW_W     (ROW_W),
        .WR_ROWS   (WR_ROWS),
        .STAT_ROWS (STAT_ROWS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .wr_data   (wr_data),
        .rd_row    (rd_row),
        .stat_flat (stat_flat),
        .rd_data   (rd_data),
        .ctrl_flat (ctrl_bits)
    );

endmodule

// File: rtl/rfs_regfile_chk.sv
module rfs_regfile_chk #(
    parameter int ROW_W      = 8,
    parameter int WR_ROWS    = 24,
    parameter int IDX_W      = 5,
    parameter int CNT_W      = 5,
    parameter int FRAME_BITS = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [WR_ROWS*ROW_W-1:0] ctrl_bits,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_row,
    input logic [ROW_W-1:0]         wr_data,
    input logic [CNT_W-1:0]         bit_cnt
);

    logic             seen_q;
    logic [IDX_W-1:0] row_q;
    logic [ROW_W-1:0] data_q;
    logic [ROW_W-1:0] landed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            row_q  <= '0;
            data_q <= '0;
        end else begin
            seen_q <= wr_en && (int'(wr_row) < WR_ROWS);
            row_q  <= wr_row;
            data_q <= wr_data;
        end
    end

    always_comb begin
        landed = '0;
        for (int r = 0; r < WR_ROWS; r++) begin
            if (int'(row_q) == r) landed = ctrl_bits[r*ROW_W +: ROW_W];
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_bits == '0);

    // R2
    commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> landed == data_q);

    // R3
    no_early_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_bits) |-> $past(wr_en));

    // R5
    ro_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_row) < WR_ROWS);

    // R6
    count_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == CNT_W'(FRAME_BITS));

endmodule

bind ctl_regfile_slave rfs_regfile_chk #(
    .ROW_W      (ROW_W),
    .WR_ROWS    (WR_ROWS),
    .IDX_W      (ROW_IDX_W),
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_bits (ctrl_bits),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_data   (wr_data),
    .bit_cnt   (bit_cnt)
);

// File: tb/sim_ctl_regfile_slave.sv
`timescale 1ns/1ps
module sim_ctl_regfile_slave;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en_n = 1'b1;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic [191:0] ctrl_bits;
    logic stat_lock = 1'b0, stat_amp_dn = 1'b0, stat_amp_up = 1'b0, stat_amp_ctr = 1'b0;
    logic [7:0] stat_tune_p = 8'h00, stat_tune_n = 8'h00;
    logic [4:0] stat_temp = 5'b00000;

    always #2.5 clk = ~clk;

    ctl_regfile_slave u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ctrl_bits(ctrl_bits),
        .stat_lock(stat_lock), .stat_amp_dn(stat_amp_dn), .stat_amp_up(stat_amp_up),
        .stat_amp_ctr(stat_amp_ctr), .stat_tune_p(stat_tune_p),
        .stat_tune_n(stat_tune_n), .stat_temp(stat_temp)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    int settle = 0;

    // Reference model: plain row list plus expected flat bus
    logic [7:0]   mdl_rows [24];
    logic [191:0] exp_flat = '0;
    logic [191:0] exp_old  = '0;

    function automatic logic [191:0] pack_rows();
        logic [191:0] v;
        for (int r = 0; r < 24; r++) v[r*8 +: 8] = mdl_rows[r];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(int row);
        if (row < 24)  return mdl_rows[row];
        if (row == 24) return {4'b0000, stat_lock, stat_amp_dn, stat_amp_up, stat_amp_ctr};
        if (row == 25) return stat_tune_p;
        if (row == 26) return stat_tune_n;
        if (row == 27) return {3'b000, stat_temp};
        return 8'h00;
    endfunction

    task automatic check_val(string req, logic [191:0] act, logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Every-clock comparison of the control bus against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit ok;
            if (settle > 0) begin
                ok = (ctrl_bits === exp_flat) || (ctrl_bits === exp_old);
                settle--;
            end else begin
                ok = (ctrl_bits === exp_flat);
            end
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL R3/R10 per-clock actual=%h expected=%h", ctrl_bits, exp_flat);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Sends nbits of frame fr, then raises enable; returns before raise via check
    task automatic send_frame(logic [17:0] fr, int nbits, bit commit, int row, logic [7:0] data);
        ser_en_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 18) ? fr[i] : 1'b0;
            tick(4);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
        end
        tick(4);
        // R3: all clocks given, enable still low, nothing may have changed
        check_val("R3 before enable rise", ctrl_bits, exp_flat);
        ser_en_n = 1'b1;
        ser_din  = 1'b0;
        if (commit) begin
            exp_old = exp_flat;
            mdl_rows[row] = data;
            exp_flat = pack_rows();
            settle = 8;
        end
        tick(10);
    endtask

    function automatic logic [17:0] mk(logic [7:0] d, logic [5:0] a, bit rw, logic [2:0] chip);
        return {chip, rw, a, d};
    endfunction

    task automatic wr(logic [5:0] a, logic [7:0] d, logic [2:0] chip, int nbits);
        bit ok;
        ok = (nbits == 18) && (chip == 3'b111) && (a[5] == 1'b0) && (int'(a) < 24);
        send_frame(mk(d, a, 1'b1, chip), nbits, ok, int'(a[4:0]), d);
    endtask

    task automatic rd(logic [5:0] a, logic [2:0] chip, int nclk, output logic [15:0] got);
        got = '0;
        send_frame(mk(8'h00, a, 1'b0, chip), 18, 1'b0, 0, 8'h00);
        ser_en_n = 1'b0;
        tick(4);
        for (int i = 0; i < nclk; i++) begin
            got[i] = ser_dout;
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(4);
        end
        ser_en_n = 1'b1;
        tick(10);
        // R8: output idle outside the readout window
        check_val("R8 dout idle after window", {191'b0, ser_dout}, 192'b0);
    endtask

    task automatic rd_check(string req, int row, logic [15:0] exp16, logic [2:0] chip, int nclk);
        logic [15:0] got;
        rd(6'(row), chip, nclk, got);
        check_val(req, {176'b0, got}, {176'b0, exp16});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        for (int r = 0; r < 24; r++) mdl_rows[r] = 8'h00;
        exp_flat = pack_rows();
        exp_old  = exp_flat;
        tick(6);
        // R1: reset state
        check_val("R1 ctrl during reset", ctrl_bits, 192'b0);
        check_val("R1 dout during reset", {191'b0, ser_dout}, 192'b0);
        rst_n = 1'b1;
        tick(4);
        check_val("R1 ctrl after reset", ctrl_bits, 192'b0);
        cmp_on = 1'b1;

        stat_lock = 1'b1; stat_amp_dn = 1'b0; stat_amp_up = 1'b1; stat_amp_ctr = 1'b0;
        stat_tune_p = 8'hA5; stat_tune_n = 8'h3C; stat_temp = 5'b00111;

        // R2 / R10: writes at both ends of the writable range
        wr(6'd0, 8'h5A, 3'b111, 18);
        check_val("R10 row0 slice", {184'b0, ctrl_bits[7:0]}, {184'b0, 8'h5A});
        wr(6'd23, 8'hC3, 3'b111, 18);
        check_val("R10 row23 slice", {184'b0, ctrl_bits[191:184]}, {184'b0, 8'hC3});
        wr(6'd9, 8'h81, 3'b111, 18);
        check_val("R2 full bus", ctrl_bits, exp_flat);

        // R8: readback of written rows, LSB first
        rd_check("R8 read row0", 0, {8'h00, exp_read(0)}, 3'b111, 8);
        rd_check("R8 read row23", 23, {8'h00, exp_read(23)}, 3'b111, 8);
        // R8: bits after the eighth are zero
        rd_check("R8 extra clocks", 9, {8'h00, exp_read(9)}, 3'b111, 12);

        // R4: foreign device addresses
        wr(6'd5, 8'hFF, 3'b110, 18);
        check_val("R4 wrong chip 110", ctrl_bits, exp_flat);
        wr(6'd5, 8'hFF, 3'b011, 18);
        check_val("R4 wrong chip 011", ctrl_bits, exp_flat);
        rd_check("R4 read wrong chip", 0, 16'h0000, 3'b101, 8);

        // R6: wrong clock counts
        wr(6'd6, 8'h66, 3'b111, 17);
        check_val("R6 seventeen clocks", ctrl_bits, exp_flat);
        wr(6'd6, 8'h66, 3'b111, 19);
        check_val("R6 nineteen clocks", ctrl_bits, exp_flat);

        // R7: address bit 5 set (would otherwise be row 5)
        wr(6'h25, 8'h99, 3'b111, 18);
        check_val("R7 high address bit", ctrl_bits, exp_flat);

        // R5: read-only and unstored rows
        wr(6'd25, 8'h00, 3'b111, 18);
        check_val("R5 write ro row bus", ctrl_bits, exp_flat);
        rd_check("R5 ro row25 keeps status", 25, {8'h00, 8'hA5}, 3'b111, 8);
        wr(6'd30, 8'h77, 3'b111, 18);
        rd_check("R5 unused row30 reads 0", 30, 16'h0000, 3'b111, 8);
        rd_check("R5 unused row31 reads 0", 31, 16'h0000, 3'b111, 8);

        // R9: status mapping
        rd_check("R9 row24 flags", 24, {8'h00, 8'b0000_1010}, 3'b111, 8);
        rd_check("R9 row26 tune_n", 26, {8'h00, 8'h3C}, 3'b111, 8);
        rd_check("R9 row27 temp mid", 27, {8'h00, 8'b0000_0111}, 3'b111, 8);
        stat_temp = 5'b11111;
        rd_check("R9 row27 temp hottest", 27, {8'h00, 8'b0001_1111}, 3'b111, 8);
        stat_temp = 5'b00000;
        stat_lock = 1'b0; stat_amp_ctr = 1'b1;
        rd_check("R9 row27 temp coldest", 27, 16'h0000, 3'b111, 8);
        rd_check("R9 row24 flags changed", 24, {8'h00, 8'b0000_0011}, 3'b111, 8);

        // R2: overwrite keeps the last value
        wr(6'd0, 8'h11, 3'b111, 18);
        rd_check("R2 overwrite row0", 0, {8'h00, 8'h11}, 3'b111, 8);
        check_val("R2 final bus", ctrl_bits, exp_flat);

        tick(10);
        cmp_on = 1'b0;
        report();
    end

endmodule